// File: doc/BRIEF.md
# Preloadable Up-Counting Interval Timer

This block is a periodic interval timer with a 16-bit counter. The counter counts upward from a programmable start value. A divider reduces the system clock to a fixed 160 kHz tick, and the counter advances by one on every tick while it runs. When the counter passes 0xFFFF, it reloads from the preload register on that same tick and raises a pending interrupt flag. The period is therefore (65536 − preload) ticks. A preload of 63936 gives 1600 ticks, which is 100 Hz.

Software reaches the timer through a small register port: a 2-bit address, a write strobe, write data, and read data that is always valid. The port holds four registers. The first is the preload value. The second is the live count, which is read-only. The third is a run-control code. The fourth is the interrupt control register, which holds the enable, the priority level and the pending/acknowledge bit. The block drives an interrupt request, together with the level that the request carries.

The run control is a three-state machine:
- **TMR_IDLE**: cleared, count at 0.
- **TMR_HALT**: stopped, count held.
- **TMR_RUN**: counting.

Its transitions are:
- **clear**: any state goes to TMR_IDLE on code 0.
- **stop**: any state goes to TMR_HALT on code 1 or code 2.
- **start**: TMR_IDLE goes to TMR_RUN on code 3 and loads the preload value.
- **resume**: TMR_HALT goes to TMR_RUN on code 3 and keeps the held count.
- **keep**: TMR_RUN stays in TMR_RUN on code 3.

Top module: `ivl_timer`

## Requirements
- R1: After reset, the count, preload and interrupt control registers all read 0. The control register reads 0 (TMR_IDLE), and irq_req is low.
- R2: The register addresses are: 0 is preload (read/write), 1 is count (read-only, writes ignored), 2 is control, and 3 is interrupt control. The interrupt control register reads as {bit 7 pending, bit 3 enable, bits 2:0 level} with all other bits 0.
- R3: Writing control code 3 in TMR_IDLE loads the preload into the count in that write's cycle. The count then increments once every DIV system cycles, and the first increment comes DIV cycles after the write.
- R4: On the tick where the count is 0xFFFF, the count reloads from the preload register and the pending flag sets on the same edge. With preload P, the period is (65536 − P)·DIV cycles.
- R5: Control code 1 stops the count and holds its value. Code 3 from TMR_HALT resumes from the held value, not from the preload. The control register reads back 1 while stopped and 3 while running.
- R6: Control code 0 sets the count to 0 and enters TMR_IDLE without changing the pending flag. Code 2 behaves as code 1.
- R7: A preload write while running does not change the count. The new value first appears at the next reload.
- R8: Writing the interrupt control register with bit 7 = 1 clears the pending flag. If a wrap occurs on the same edge, the wrap wins.
- R9: irq_req is high exactly while the flag is pending and enabled. irq_level equals the programmed level while irq_req is high and is 0 otherwise.
- R10: The tick divider is DIV = SYS_CLK_HZ / TICK_HZ. A preload of 63936 produces a wrap every 1600 ticks (100 Hz at a 160 kHz tick).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register, combinational |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority level carried with the request |

## Verification
A register write takes effect on the edge where the strobe is sampled, and readback shows the new value in the cycle right after that edge. The first count increment after a start or resume comes DIV cycles after the control write. Each later increment follows DIV cycles after the one before. A wrap shows in the count and in irq_req on the same edge, which is (0x10000 − count)·DIV cycles after the last known count. The bench works out each due cycle from the edge index of the write and places every expected item in the scoreboard under that exact cycle. The monitor compares only at the falling edge of that cycle, and it also checks irq_req one cycle earlier to confirm that nothing arrives early.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Run state; the encoding doubles as the control readback code
    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_HALT = 2'd1,
        TMR_RUN  = 2'd3
    } tmr_state_e;

    localparam logic [1:0] ADDR_PRELOAD = 2'd0;
    localparam logic [1:0] ADDR_COUNT   = 2'd1;
    localparam logic [1:0] ADDR_CTRL    = 2'd2;
    localparam logic [1:0] ADDR_ICR     = 2'd3;

    localparam logic [1:0] CODE_CLEAR = 2'd0;
    localparam logic [1:0] CODE_START = 2'd3;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pre;

            // Prescaler restarts whenever the timer is not running
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    pre <= '0;
                end else if (pre == LAST) begin
                    pre <= '0;
                end else begin
                    pre <= pre + 1'b1;
                end
            end

            assign tick = run && (pre == LAST);

            assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ctrl_wr,
    input  logic [1:0]   ctrl_code,
    input  logic [W-1:0] preload,
    output logic [W-1:0] count,
    output tmr_state_e   state,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = '1;

    tmr_state_e state_nx;

    // Transitions: clear, stop, start/resume/keep
    always_comb begin
        state_nx = state;
        if (ctrl_wr) begin
            unique case (ctrl_code)
                CODE_CLEAR: state_nx = TMR_IDLE;
                CODE_START: state_nx = TMR_RUN;
                default:    state_nx = TMR_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TMR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    assign wrap = (state == TMR_RUN) && tick && (count == CNT_MAX);

    // Count datapath driven by the state and the control strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (ctrl_wr && ctrl_code == CODE_CLEAR) begin
            count <= '0;
        end else if (ctrl_wr && ctrl_code == CODE_START && state == TMR_IDLE) begin
            count <= preload;
        end else if (state == TMR_RUN && tick) begin
            count <= wrap ? preload : count + 1'b1;
        end
    end

    assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_code == CODE_START && state == TMR_IDLE) |=> count == $past(preload));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ctrl_wr) |=> count == $past(preload));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TMR_HALT && !ctrl_wr) |=> $stable(count));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_code == CODE_CLEAR) |=> (count == '0 && state == TMR_IDLE));
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap,
    input  logic          icr_wr,
    input  logic          ack_bit,
    input  logic          en_bit,
    input  logic [LW-1:0] level_bits,
    output logic          pending,
    output logic          enable,
    output logic [LW-1:0] level,
    output logic          irq,
    output logic [LW-1:0] irq_level
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            enable  <= 1'b0;
            level   <= '0;
        end else begin
            if (wrap) begin
                pending <= 1'b1;
            end else if (icr_wr && ack_bit) begin
                pending <= 1'b0;
            end
            if (icr_wr) begin
                enable <= en_bit;
                level  <= level_bits;
            end
        end
    end

    always_comb begin
        irq       = pending && enable;
        irq_level = irq ? level : '0;
    end

    assert_wrap_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> pending);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (icr_wr && ack_bit && !wrap) |=> !pending);

    assert_pending_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(wrap));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import tmr_pkg::*;
#(
    parameter int SYS_CLK_HZ = 16_000_000,
    parameter int TICK_HZ    = 160_000,
    parameter int CNT_W      = 16,
    parameter int LVL_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq_req,
    output logic [LVL_W-1:0] irq_level
);
    localparam int DIV = SYS_CLK_HZ / TICK_HZ;
    localparam int ACK_BIT = 7;
    localparam int EN_BIT  = LVL_W;

    logic [CNT_W-1:0] preload_q;
    logic [CNT_W-1:0] count;
    tmr_state_e       state;
    logic             tick, wrap;
    logic             pending, enable;
    logic [LVL_W-1:0] level;

    wire wr_pre  = reg_wr && reg_addr == ADDR_PRELOAD;
    wire wr_ctrl = reg_wr && reg_addr == ADDR_CTRL;
    wire wr_icr  = reg_wr && reg_addr == ADDR_ICR;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_q <= '0;
        end else if (wr_pre) begin
            preload_q <= reg_wdata;
        end
    end

    tmr_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == TMR_RUN),
        .tick (tick)
    );

    tmr_count_fsm #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctrl_wr  (wr_ctrl),
        .ctrl_code(reg_wdata[1:0]),
        .preload  (preload_q),
        .count    (count),
        .state    (state),
        .wrap     (wrap)
    );

    tmr_irq_ctl #(.LW(LVL_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .icr_wr    (wr_icr),
        .ack_bit   (reg_wdata[ACK_BIT]),
        .en_bit    (reg_wdata[EN_BIT]),
        .level_bits(reg_wdata[LVL_W-1:0]),
        .pending   (pending),
        .enable    (enable),
        .level     (level),
        .irq       (irq_req),
        .irq_level (irq_level)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_PRELOAD: reg_rdata = preload_q;
            ADDR_COUNT:   reg_rdata = count;
            ADDR_CTRL:    reg_rdata = CNT_W'(state);
            ADDR_ICR: begin
                reg_rdata[ACK_BIT]     = pending;
                reg_rdata[EN_BIT]      = enable;
                reg_rdata[LVL_W-1:0]   = level;
            end
            default:      reg_rdata = '0;
        endcase
    end

    assert_count_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_COUNT && state != TMR_RUN) |=> $stable(count));

    assert_level_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending) |-> irq_level == '0);
endmodule

// File: tb/tb_ivl_timer.sv
module tb_ivl_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;

    typedef struct {
        int          cyc;
        int          kind;   // 0 rdata, 1 irq_req, 2 irq_level
        logic [15:0] val;
        string       req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_req;
    logic [2:0]  irq_level;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    sb_item_t sb[$];

    ivl_timer #(.SYS_CLK_HZ(640_000), .TICK_HZ(160_000)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_level(irq_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every item due in this cycle and compare
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                logic [15:0] act;
                act = (sb[i].kind == 0) ? reg_rdata :
                      (sb[i].kind == 1) ? {15'd0, irq_req} : {13'd0, irq_level};
                n_cmp++;
                if (act !== sb[i].val) begin
                    n_bad++;
                    $display("FAIL %s kind %0d cyc %0d: actual %h expected %h",
                             sb[i].req, sb[i].kind, cyc, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    function automatic int adv(int c, int n, int p);
        for (int i = 0; i < n; i++) c = (c == 65535) ? p : c + 1;
        return c;
    endfunction

    task automatic push(int c, int kind, logic [15:0] v, string req);
        sb_item_t it;
        it.cyc = c; it.kind = kind; it.val = v; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wait_until(int c);
        while (cyc < c) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic rd_at(int c, logic [1:0] a, logic [15:0] exp, string req);
        wait_until(c);
        reg_addr = a;
        push(c, 0, exp, req);
    endtask

    task automatic rd(logic [1:0] a, logic [15:0] exp, string req);
        @(posedge clk);
        #1;
        reg_addr = a;
        push(cyc, 0, exp, req);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(posedge clk);
        #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            n_bad += sb.size();
            foreach (sb[i]) $display("FAIL %s never compared, expected %h", sb[i].req, sb[i].val);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, actual running expected finished");
        finish_run();
    end

    initial begin
        int k, s, r, p, w, held, cp, m0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(2'd1, 16'h0000, "R1 count");
        rd(2'd0, 16'h0000, "R1 preload");
        rd(2'd2, 16'h0000, "R1 ctrl");
        rd(2'd3, 16'h0000, "R1 icr");
        push(cyc, 1, 16'd0, "R1 irq");
        // R2 register map and readback
        wr(2'd0, 16'hFFFC);
        wr(2'd3, 16'h00FD);             // bits 6:4 must not stick
        rd(2'd0, 16'hFFFC, "R2 preload");
        rd(2'd3, 16'h000D, "R2 icr");
        // R3 start loads preload, R4 wrap and reload
        wr(2'd2, 16'd3);
        k = cyc;
        push(k + 15, 1, 16'd0, "R4 irq early");
        push(k + 16, 1, 16'd1, "R4 irq at wrap");
        push(k + 16, 2, 16'd5, "R9 level");
        push(k + 15, 2, 16'd0, "R9 level quiet");
        rd_at(k, 2'd1, 16'hFFFC, "R3 start load");
        rd_at(k + 3, 2'd1, 16'hFFFC, "R3 before tick");
        rd_at(k + 4, 2'd1, 16'hFFFD, "R3 first tick");
        rd_at(k + 15, 2'd1, 16'hFFFF, "R3 top");
        rd_at(k + 16, 2'd1, 16'hFFFC, "R4 reload");
        rd_at(k + 17, 2'd3, 16'h008D, "R2 pending bit");
        // R8 acknowledge
        wait_until(k + 20);
        wr(2'd3, 16'h008D);
        push(cyc, 1, 16'd0, "R8 ack");
        push(k + 32, 1, 16'd1, "R4 second wrap");
        wait_until(k + 34);
        wr(2'd3, 16'h008D);
        push(cyc, 1, 16'd0, "R8 ack again");
        // R5 stop and hold
        wr(2'd2, 16'd1);
        s = cyc;
        held = adv(16'hFFFC, (s - k) / DIV, 16'hFFFC);
        rd_at(s, 2'd1, 16'(held), "R5 stop value");
        rd_at(s + 20, 2'd1, 16'(held), "R5 held");
        rd(2'd2, 16'd1, "R5 ctrl stopped");
        // R2 count is read-only
        wr(2'd1, 16'h1234);
        rd(2'd1, 16'(held), "R2 count write ignored");
        // R5 resume from held value
        wr(2'd2, 16'd3);
        r = cyc;
        rd_at(r, 2'd1, 16'(held), "R5 resume keeps count");
        rd_at(r + 4, 2'd1, 16'(adv(held, 1, 16'hFFFC)), "R5 resume tick");
        rd(2'd2, 16'd3, "R5 ctrl running");
        // R7 preload change while running
        wr(2'd0, 16'hFFF0);
        p = cyc;
        m0 = (p - r) / DIV;
        cp = adv(held, m0, 16'hFFFC);
        rd_at(p, 2'd1, 16'(cp), "R7 no immediate effect");
        w = r + DIV * (m0 + 65536 - cp);
        push(w, 1, 16'd1, "R4 wrap after preload change");
        rd_at(w, 2'd1, 16'hFFF0, "R7 new preload at reload");
        rd_at(w + 4, 2'd1, 16'hFFF1, "R7 counts from new preload");
        // R6 clear keeps pending
        wr(2'd2, 16'd0);
        rd(2'd1, 16'h0000, "R6 clear count");
        rd(2'd2, 16'h0000, "R6 ctrl idle");
        rd(2'd3, 16'h008D, "R6 pending kept");
        wr(2'd2, 16'd2);
        rd(2'd2, 16'd1, "R6 code 2 stops");
        rd(2'd1, 16'h0000, "R6 code 2 holds");
        // R9 gating by enable
        wr(2'd3, 16'h0005);
        push(cyc, 1, 16'd0, "R9 disabled irq");
        push(cyc, 2, 16'd0, "R9 disabled level");
        rd(2'd3, 16'h0085, "R9 pending while disabled");
        wr(2'd3, 16'h0085);
        rd(2'd3, 16'h0005, "R8 ack while disabled");
        // R10 100 Hz preload
        wr(2'd2, 16'd0);
        wr(2'd0, 16'd63936);
        wr(2'd3, 16'h000B);
        wr(2'd2, 16'd3);
        k = cyc;
        rd_at(k, 2'd1, 16'd63936, "R10 load");
        push(k + 1600 * DIV - 1, 1, 16'd0, "R10 not early");
        push(k + 1600 * DIV, 1, 16'd1, "R10 period");
        push(k + 1600 * DIV, 2, 16'd3, "R10 level");
        rd_at(k + 1600 * DIV, 2'd1, 16'd63936, "R10 reload");
        wait_until(k + 1600 * DIV + 3);
        finish_run();
    end
endmodule